// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is an I2C bus master that software steers one bus operation at a time through a small byte-wide register file. Software writes an operation code with a go bit into the command register. The engine then carries out exactly one operation: a START, a repeated START, a byte write with acknowledge sampling, a byte read that answers ACK or NACK, or a STOP. When the operation ends, the engine posts a two-bit completion status in the command register and raises a completion flag. An enable bit gates that flag onto the interrupt output.

Any sequencing at the message level is left to software. The SCL period is set by an 8-bit clock-time register and is 64 × (clock-time + 1) system clocks. Each SCL period is split into four equal phases. SCL and SDA are open-drain lines, so the block drives each one through an active-high pull-low enable and reads SDA back through an input pin. A soft-reset bit in the control register holds the engine idle.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, every register reads 0 and both line enables (`scl_oe`, `sda_oe`) are 0. The registers sit at offset 0x0 (control, bit 0 soft reset), 0x1 (clock time), 0x2 (command), 0x3 (data), 0x8 (flag; writing bit 0 as 1 clears it) and 0xA (interrupt enable, bit 0).
- R2: A write to 0x2 with bit 7 set launches the code held in bits 3:0. While the operation runs, bit 7 of 0x2 reads 1, and it clears when the operation completes. A go write that arrives while busy is ignored.
- R3: Each phase lasts 16 × (clock-time + 1) clocks. START (code 1), repeated START (code 2) and STOP (code 10) take 4 phases. Byte operations take 36 phases (9 SCL pulses).
- R4: START and repeated START pull SDA low while SCL is high. Both end with SCL and SDA held low and status 0. Status is read from bits 6:5 of 0x2.
- R5: Code 3 shifts out the data register MSB first on 8 pulses and releases SDA on the ninth pulse. The ninth pulse is sampled: status is 1 if SDA was low there, 2 if it was high.
- R6: Codes 6 and 7 release SDA for 8 pulses and shift SDA MSB first into the data register. On the ninth pulse, code 6 drives SDA low and code 7 releases it. Status is 0.
- R7: STOP releases SDA while SCL is high, ends with both lines released, and sets status 0.
- R8: Outside START, repeated START and STOP, SDA changes only while SCL is low.
- R9: A byte code or STOP issued while no START is active on the bus, or any code not listed above, completes at once with status 3. It sets no busy state and does not move either line.
- R10: Every completion, including an abort, sets the flag. Writing 1 to bit 0 of 0x8 clears the flag. `irq` is high only while the flag is set and bit 0 of 0xA is 1.
- R11: While bit 0 of 0x0 is 1, the engine drops any running operation, releases both lines, clears the flag and forgets that a START is active. Go writes are ignored in this state. Clearing the bit returns the engine to normal operation.
- R12: Writes to the data register are ignored while an operation is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from offset |
| irq | output | 1 | Completion interrupt |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
Call the clock edge that samples a go write E. The busy bit reads 1 from the first falling edge after E. It clears on the falling edge that comes 4 × Q clocks after E for START, repeated START and STOP, and 36 × Q clocks after E for byte operations, where Q is the phase length. The bench counts falling edges from E while polling the busy bit and compares that count with these exact figures. An abort posts status 3 and the flag by the first falling edge after E. The soft-reset bit becomes active one edge after its write, and the line release follows one edge later, so the bench checks the lines one further falling edge on. A bus model in the bench samples SDA on each SCL rise and records START and STOP conditions, so the checks cover bit order and acknowledge handling as well as timing, across swept byte values and several clock-time settings.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_CLKT = 4'h1;
    localparam logic [ADDR_W-1:0] A_CMD  = 4'h2;
    localparam logic [ADDR_W-1:0] A_DATA = 4'h3;
    localparam logic [ADDR_W-1:0] A_FCLR = 4'h8;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'hA;

    localparam logic [3:0] OP_START   = 4'd1;
    localparam logic [3:0] OP_RSTART  = 4'd2;
    localparam logic [3:0] OP_WRITE   = 4'd3;
    localparam logic [3:0] OP_RD_ACK  = 4'd6;
    localparam logic [3:0] OP_RD_NACK = 4'd7;
    localparam logic [3:0] OP_STOP    = 4'd10;

    localparam logic [1:0] ST_OK    = 2'd0;
    localparam logic [1:0] ST_ACK   = 2'd1;
    localparam logic [1:0] ST_NACK  = 2'd2;
    localparam logic [1:0] ST_ABORT = 2'd3;

    typedef struct packed {
        logic              srst;
        logic [DATA_W-1:0] clkt;
        logic              busy;
        logic [3:0]        op;
        logic [1:0]        status;
        logic [DATA_W-1:0] data;
        logic              flag;
        logic              ien;
        logic              bus_on;
        logic [3:0]        slot;
        logic [1:0]        phase;
        logic              scl_low;
        logic              sda_low;
    } eng_t;

    function automatic logic is_read(input logic [3:0] op);
        return (op == OP_RD_ACK) || (op == OP_RD_NACK);
    endfunction

    function automatic logic is_byte(input logic [3:0] op);
        return (op == OP_WRITE) || is_read(op);
    endfunction

    // Returns {pull SCL low, pull SDA low} for one phase of one slot
    function automatic logic [1:0] line_drive(input logic [3:0] op,
                                              input logic [3:0] slot,
                                              input logic [1:0] ph,
                                              input logic [DATA_W-1:0] tx);
        logic scl_l;
        logic sda_l;
        scl_l = (ph == 2'd0) || (ph == 2'd3);
        sda_l = 1'b0;
        case (op)
            OP_START: begin
                scl_l = (ph == 2'd3);
                sda_l = ph[1];
            end
            OP_RSTART: sda_l = ph[1];
            OP_STOP: begin
                scl_l = (ph == 2'd0);
                sda_l = !ph[1];
            end
            OP_WRITE:  sda_l = (slot < 4'd8) ? !tx[3'(4'd7 - slot)] : 1'b0;
            OP_RD_ACK: sda_l = (slot == 4'd8);
            default:   sda_l = 1'b0;
        endcase
        return {scl_l, sda_l};
    endfunction

endpackage

// File: rtl/i2cb_phase_timer.sv
module i2cb_phase_timer #(
    parameter int CT_W   = 8,
    parameter int PH_MUL = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [CT_W-1:0] clkt,
    output logic            tick
);
    localparam int CNT_W = CT_W + $clog2(PH_MUL);

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = CNT_W'(clkt) * CNT_W'(PH_MUL) + CNT_W'(PH_MUL - 1);
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cb_regread.sv
module i2cb_regread
    import i2cb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              srst,
    input  logic [DATA_W-1:0] clkt,
    input  logic              busy,
    input  logic [1:0]        status,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] data,
    input  logic              flag,
    input  logic              ien,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {7'd0, srst};
            A_CLKT:  rdata = clkt;
            A_CMD:   rdata = {busy, status, 1'b0, op};
            A_DATA:  rdata = data;
            A_FCLR:  rdata = {7'd0, flag};
            A_IEN:   rdata = {7'd0, ien};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cb_pkg::*;
#(
    parameter int PH_MUL = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    eng_t r_d, r_q;
    logic tick;
    logic go_wr;
    logic launch_ok;
    logic [3:0] new_op;

    i2cb_phase_timer #(.CT_W(DATA_W), .PH_MUL(PH_MUL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.busy),
        .clkt (r_q.clkt),
        .tick (tick)
    );

    i2cb_regread u_rd (
        .addr  (reg_addr),
        .srst  (r_q.srst),
        .clkt  (r_q.clkt),
        .busy  (r_q.busy),
        .status(r_q.status),
        .op    (r_q.op),
        .data  (r_q.data),
        .flag  (r_q.flag),
        .ien   (r_q.ien),
        .rdata (reg_rdata)
    );

    always_comb begin
        r_d       = r_q;
        go_wr     = reg_wr && (reg_addr == A_CMD) && reg_wdata[7];
        new_op    = reg_wdata[3:0];
        launch_ok = (new_op == OP_START) || (new_op == OP_RSTART) ||
                    ((is_byte(new_op) || (new_op == OP_STOP)) && r_q.bus_on);

        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  r_d.srst = reg_wdata[0];
                A_CLKT:  r_d.clkt = reg_wdata;
                A_DATA:  if (!r_q.busy) r_d.data = reg_wdata;
                A_FCLR:  if (reg_wdata[0]) r_d.flag = 1'b0;
                A_IEN:   r_d.ien = reg_wdata[0];
                default: ;
            endcase
        end

        if (r_q.srst) begin
            r_d.busy    = 1'b0;
            r_d.bus_on  = 1'b0;
            r_d.slot    = '0;
            r_d.phase   = '0;
            r_d.scl_low = 1'b0;
            r_d.sda_low = 1'b0;
            r_d.flag    = 1'b0;
        end else if (r_q.busy) begin
            if (tick) begin
                if (r_q.phase == 2'd2) begin
                    if (is_read(r_q.op) && (r_q.slot < 4'd8))
                        r_d.data = {r_q.data[DATA_W-2:0], sda_in};
                    if ((r_q.op == OP_WRITE) && (r_q.slot == 4'd8))
                        r_d.status = sda_in ? ST_NACK : ST_ACK;
                end
                if (r_q.phase == 2'd3) begin
                    if (!is_byte(r_q.op) || (r_q.slot == 4'd8)) begin
                        r_d.busy = 1'b0;
                        r_d.flag = 1'b1;
                        if (r_q.op == OP_STOP)      r_d.bus_on = 1'b0;
                        else if (!is_byte(r_q.op))  r_d.bus_on = 1'b1;
                    end else begin
                        r_d.slot  = r_q.slot + 4'd1;
                        r_d.phase = 2'd0;
                        {r_d.scl_low, r_d.sda_low} =
                            line_drive(r_q.op, r_q.slot + 4'd1, 2'd0, r_q.data);
                    end
                end else begin
                    r_d.phase = r_q.phase + 2'd1;
                    {r_d.scl_low, r_d.sda_low} =
                        line_drive(r_q.op, r_q.slot, r_q.phase + 2'd1, r_q.data);
                end
            end
        end else if (go_wr) begin
            r_d.op = new_op;
            if (launch_ok) begin
                r_d.busy   = 1'b1;
                r_d.slot   = '0;
                r_d.phase  = '0;
                r_d.status = ST_OK;
                {r_d.scl_low, r_d.sda_low} = line_drive(new_op, 4'd0, 2'd0, r_q.data);
            end else begin
                r_d.status = ST_ABORT;
                r_d.flag   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq    = r_q.flag & r_q.ien;
    assign scl_oe = r_q.scl_low;
    assign sda_oe = r_q.sda_low;
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker
    import i2cb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              busy,
    input logic              srst,
    input logic              flag,
    input logic [3:0]        op
);
    logic go_wr;
    logic clr_wr;
    assign go_wr  = reg_wr && (reg_addr == A_CMD) && reg_wdata[7];
    assign clr_wr = reg_wr && (reg_addr == A_FCLR) && reg_wdata[0];

    assert_launch_by_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_wr));

    assert_sda_change_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)) && !$past(srst))
        |-> ((op == OP_START) || (op == OP_RSTART) || (op == OP_STOP)));

    assert_idle_lines_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !srst && !go_wr) |=> ((scl_oe == $past(scl_oe)) && (sda_oe == $past(sda_oe))));

    assert_done_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy && !$past(srst)) |-> flag);

    assert_clear_drops_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !busy && !go_wr) |=> !irq);

    assert_soft_reset_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!scl_oe && !sda_oe && !busy));
endmodule

bind i2c_byte_master i2cb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq      (irq),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (r_q.busy),
    .srst     (r_q.srst),
    .flag     (r_q.flag),
    .op       (r_q.op)
);

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slave_pull = 1'b0;
    logic       sda_in;

    assign sda_in = !(sda_oe || slave_pull);

    i2c_byte_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bus model state
    int rises, falls, starts, stops;
    logic [7:0] cap, rd_byte;
    logic ninth, ack_en, prev_scl, prev_sda;
    int mode = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        prev_scl = 1'b0; prev_sda = 1'b1;
        rises = 0; falls = 0; starts = 0; stops = 0; cap = '0; ninth = 1'b0;
        ack_en = 1'b0; rd_byte = '0;
        forever begin
            @(negedge clk);
            if (!prev_scl && !scl_oe && (prev_sda !== sda_in)) begin
                if (!sda_in) starts++;
                else         stops++;
            end
            if (prev_scl && !scl_oe) begin
                if (rises < 8)       cap = {cap[6:0], sda_in};
                else if (rises == 8) ninth = sda_in;
                rises++;
            end
            if (!prev_scl && scl_oe) falls++;
            case (mode)
                1:       slave_pull = ack_en && (falls == 8);
                2:       slave_pull = (falls < 8) ? !rd_byte[3'(7 - falls)] : 1'b0;
                default: slave_pull = 1'b0;
            endcase
            prev_scl = scl_oe;
            prev_sda = !(sda_oe || slave_pull);
        end
    end

    task automatic mon_clear();
        rises = 0; falls = 0; starts = 0; stops = 0; cap = '0; ninth = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(inout int n);
        reg_addr = 4'h2;
        #0.1;
        while (reg_rdata[7] && n < 20000) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    task automatic launch(input logic [3:0] code, output int n);
        wr(4'h2, 8'h80 | {4'h0, code});
        n = 0;
        wait_idle(n);
    endtask

    function automatic int status_of(input logic [7:0] v);
        return int'(v[6:5]);
    endfunction

    task automatic do_cond(input logic [3:0] code, input int q);
        int n;
        logic [7:0] v;
        mon_clear(); mode = 0;
        launch(code, n);
        rd(4'h2, v);
        if (code == 4'd10) begin
            chk("R3 stop length", n, 4 * q);
            chk("R7 stop condition count", stops, 1);
            chk("R7 no start", starts, 0);
            chk("R7 lines released", {30'd0, scl_oe, sda_oe}, 0);
            chk("R7 status", status_of(v), 0);
        end else begin
            chk("R3 start length", n, 4 * q);
            chk("R4 start condition count", starts, 1);
            chk("R4 no stop", stops, 0);
            chk("R4 lines held low", {30'd0, scl_oe, sda_oe}, 3);
            chk("R4 status", status_of(v), 0);
            chk("R4 rises", rises, (code == 4'd2) ? 1 : 0);
        end
    endtask

    task automatic do_write(input logic [7:0] b, input logic ack, input int q);
        int n;
        logic [7:0] v;
        wr(4'h3, b);
        mon_clear(); mode = 1; ack_en = ack;
        launch(4'd3, n);
        rd(4'h2, v);
        chk("R3 byte length", n, 36 * q);
        chk("R5 bits MSB first", int'(cap), int'(b));
        chk("R5 ninth pulse level", int'(ninth), int'(!ack));
        chk("R5 ack status", status_of(v), ack ? 1 : 2);
        chk("R8 no condition in byte", starts + stops, 0);
        chk("R5 nine pulses", rises, 9);
        mode = 0;
    endtask

    task automatic do_read(input logic [7:0] b, input logic [3:0] code, input int q);
        int n;
        logic [7:0] v;
        mon_clear(); mode = 2; rd_byte = b;
        launch(code, n);
        rd(4'h2, v);
        chk("R3 byte length", n, 36 * q);
        chk("R6 status", status_of(v), 0);
        rd(4'h3, v);
        chk("R6 received byte", int'(v), int'(b));
        chk("R6 answer bit", int'(ninth), (code == 4'd6) ? 0 : 1);
        chk("R8 no condition in byte", starts + stops, 0);
        mode = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        logic [3:0] regs [6];
        regs = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'hA};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(regs[i], v);
            chk("R1 register reset value", int'(v), 0);
        end
        chk("R1 lines released", {29'd0, scl_oe, sda_oe, irq}, 0);

        // R9 aborts with no START on the bus, R10 flag and gating
        wr(4'hA, 8'h01);
        mon_clear();
        wr(4'h2, 8'h83);
        rd(4'h2, v);
        chk("R9 abort status", status_of(v), 3);
        chk("R9 abort not busy", int'(v[7]), 0);
        chk("R10 irq after abort", int'(irq), 1);
        repeat (5) @(negedge clk);
        #1;
        chk("R9 lines untouched", rises + falls + starts + stops + int'(scl_oe) + int'(sda_oe), 0);
        wr(4'h8, 8'h01);
        rd(4'h8, v);
        chk("R10 flag cleared", int'(v), 0);
        chk("R10 irq cleared", int'(irq), 0);
        wr(4'h2, 8'h8A);
        rd(4'h2, v);
        chk("R9 stop abort", status_of(v), 3);
        wr(4'h2, 8'h85);
        rd(4'h2, v);
        chk("R9 unknown code abort", status_of(v), 3);
        wr(4'h8, 8'h01);

        // clock time 0: sweeps
        do_cond(4'd1, 16);
        chk("R10 flag after start", int'(irq), 1);
        wr(4'hA, 8'h00);
        rd(4'h8, v);
        chk("R10 gated irq low", int'(irq), 0);
        chk("R10 flag kept", int'(v), 1);
        wr(4'hA, 8'h01);
        for (int k = 0; k < 16; k++) do_write(8'(k * 17), k[0], 16);
        for (int k = 0; k < 16; k++) do_read(8'(k * 17) ^ 8'hA5, k[0] ? 4'd7 : 4'd6, 16);
        do_cond(4'd2, 16);

        // R2 go ignored while busy, R12 data write ignored while busy
        wr(4'h3, 8'hC3);
        mon_clear(); mode = 1; ack_en = 1'b1;
        wr(4'h2, 8'h83);
        rd(4'h2, v);
        chk("R2 go bit reads busy", int'(v[7]), 1);
        n = 0;
        repeat (50) begin @(negedge clk); n++; end
        wr(4'h2, 8'h8A);
        wr(4'h3, 8'h00);
        n += 4;
        wait_idle(n);
        rd(4'h2, v);
        chk("R2 length unchanged by second go", n, 36 * 16);
        chk("R2 second go ignored", stops, 0);
        chk("R2 status of first op", status_of(v), 1);
        chk("R2 opcode kept", int'(v[3:0]), 3);
        rd(4'h3, v);
        chk("R12 data write ignored while busy", int'(v), 8'hC3);
        mode = 0;
        do_cond(4'd10, 16);

        // other clock times
        wr(4'h1, 8'd1);
        do_cond(4'd1, 32);
        do_write(8'h96, 1'b1, 32);
        do_read(8'h3C, 4'd7, 32);
        do_cond(4'd10, 32);
        wr(4'h1, 8'd3);
        do_cond(4'd1, 64);
        do_write(8'h01, 1'b0, 64);
        do_cond(4'd10, 64);
        wr(4'h1, 8'd0);

        // R11 soft reset mid-operation
        do_cond(4'd1, 16);
        wr(4'h3, 8'h00);
        wr(4'h2, 8'h83);
        repeat (40) @(negedge clk);
        wr(4'h0, 8'h01);
        @(negedge clk);
        #1;
        rd(4'h2, v);
        chk("R11 lines released", {30'd0, scl_oe, sda_oe}, 0);
        chk("R11 not busy", int'(v[7]), 0);
        chk("R11 flag cleared", int'(irq), 0);
        wr(4'h2, 8'h81);
        rd(4'h2, v);
        chk("R11 go ignored in reset", int'(v[7]), 0);
        rd(4'h0, v);
        chk("R11 control readback", int'(v), 1);
        wr(4'h0, 8'h00);
        wr(4'h2, 8'h83);
        rd(4'h2, v);
        chk("R11 bus state forgotten", status_of(v), 3);
        do_cond(4'd1, 16);
        do_cond(4'd10, 16);

        summary();
        $finish;
    end
endmodule